// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog timer. A down-counter runs off a slow, free-running tick, which the design receives as a one-cycle `tick_en` strobe in the main clock domain. Software must refresh the counter before it runs out. If it does not, the block pulses `wdg_rst_o` for one clock so that the system can be reset. Software reaches the block through a small register port with a write strobe, a byte address, write data and combinational read data.

All control goes through a key register. A start key arms the watchdog. A feed key refreshes the counter from the programmed reload value. An unlock key opens the divider and reload registers for writing, and any other key value closes them again. Once armed, the watchdog can be stopped only by the system reset. A new divider or reload value does not act at once. It takes effect after two tick strobes, and a status register reports each update while it is still pending. Software polls that register before it relies on the new timeout.

The timeout is (reload + 1) prescaled ticks. The divider is a power of two from 4 to 1024. The register port is a plain control interface with no back-pressure: every write is taken in the cycle in which `reg_we` is high.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, `wdg_rst_o` is low, the divider code reads 0, the reload reads 0xFFF, the status reads 0, and no pulse occurs however many ticks arrive before a start key.
- R2: Writes to the divider register (offset 0x04, code in bits [3:0]) or the reload register (offset 0x08, value in bits [11:0]) are ignored while locked. Readback and status stay unchanged.
- R3: Writing 0x5555 to the key register (offset 0x00) unlocks the divider and reload registers. Writing any other value to the key register locks them again, for example 0x0000 or 0x1234.
- R4: Status (offset 0x0C) bit 0 is set by an accepted divider write and bit 1 by an accepted reload write. Each bit stays set after one tick strobe and clears after the second.
- R5: Writing 0xCCCC arms the watchdog. With code 0 and reload R, `wdg_rst_o` goes high for exactly one clock after the (R+1)*4-th tick strobe, and not before.
- R6: Divider code n divides the tick by 2^(n+2). Codes above 8 saturate at 1024. Code 1 with reload 2 expires on tick 24, and code 9 with reload 0 expires on tick 1024.
- R7: Writing 0xAAAA reloads the counter and restarts the division, so the next expiry comes a full timeout after the feed.
- R8: After an expiry the counter reloads by itself, and the next pulse follows a full timeout later if no feed arrives.
- R9: Once armed, no key value stops the watchdog. Only `rst_n` stops it.
- R10: The window register at offset 0x10 is decoded but has no effect. It reads 0, and writing it while unlocked changes neither status nor the other registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low system reset; the only way to stop an armed watchdog |
| tick_en | input | 1 | One-cycle strobe for each slow-clock tick |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| wdg_rst_o | output | 1 | One-clock reset request on expiry |

## Verification
The hardest case to reach from the ports is the saturated divider. A code above 8 only shows its effect after more than a thousand tick strobes, and the only visible mark is whether the pulse lands on tick 1023 or tick 1024. The bench programs code 9 with reload 0 and counts strobes one by one. The other hard part is telling "update still pending" apart from "update applied". For that, the bench reads status between the first and second tick strobe, and it arms the counter only after the status has cleared.

// File: rtl/kwdg_pkg.sv
package kwdg_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] OFS_KEY  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_DIV  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_LOAD = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_WIN  = 5'h10;

  localparam logic [DATA_W-1:0] KEY_START = 16'hCCCC;
  localparam logic [DATA_W-1:0] KEY_FEED  = 16'hAAAA;
  localparam logic [DATA_W-1:0] KEY_OPEN  = 16'h5555;

  typedef struct packed {
    logic start;
    logic feed;
  } key_cmd_t;
endpackage

// File: rtl/kwdg_keyctl.sv
module kwdg_keyctl
  import kwdg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_val,
  output logic              unlocked,
  output key_cmd_t          cmd
);
  // Every key write decides the lock: only the open key leaves it open.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      unlocked <= 1'b0;
    else if (key_wr) unlocked <= (key_val == KEY_OPEN);
  end

  always_comb begin
    cmd.start = key_wr && (key_val == KEY_START);
    cmd.feed  = key_wr && (key_val == KEY_FEED);
  end
endmodule

// File: rtl/kwdg_cfg_field.sv
module kwdg_cfg_field #(
  parameter int          W      = 12,
  parameter logic [W-1:0] RST   = '0,
  parameter int          SETTLE = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         tick_en,
  output logic [W-1:0] shadow,
  output logic [W-1:0] active,
  output logic         pending
);
  localparam int CW = $clog2(SETTLE + 1);

  logic [CW-1:0] settle_q;

  // A write restarts the settle window; the value moves to the active
  // copy on the tick that empties the window.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow   <= RST;
      active   <= RST;
      settle_q <= '0;
    end else if (wr) begin
      shadow   <= wdata;
      settle_q <= CW'(SETTLE);
    end else if (tick_en && settle_q != '0) begin
      settle_q <= settle_q - CW'(1);
      if (settle_q == CW'(1)) active <= shadow;
    end
  end

  assign pending = (settle_q != '0);
endmodule

// File: rtl/kwdg_prescale.sv
module kwdg_prescale #(
  parameter int CODE_W   = 4,
  parameter int MIN_LOG2 = 2,
  parameter int MAX_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic              tick_en,
  input  logic [CODE_W-1:0] code,
  output logic              ptick
);
  localparam int LW = $clog2(MAX_LOG2 + 1);

  logic [MAX_LOG2-1:0] div_q;
  logic [MAX_LOG2-1:0] term;
  logic [LW-1:0]       eff_log2;
  logic                last;

  always_comb begin
    if (int'(code) + MIN_LOG2 >= MAX_LOG2) eff_log2 = LW'(MAX_LOG2);
    else                                   eff_log2 = LW'(int'(code) + MIN_LOG2);
  end

  // Terminal count: the low eff_log2 bits are ones.
  for (genvar i = 0; i < MAX_LOG2; i++) begin : g_term
    assign term[i] = (int'(eff_log2) > i);
  end

  assign last = (div_q == term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                div_q <= '0;
    else if (restart || !run)  div_q <= '0;
    else if (tick_en)          div_q <= last ? '0 : div_q + MAX_LOG2'(1);
  end

  assign ptick = run && tick_en && last && !restart;
endmodule

// File: rtl/kwdg_downcnt.sv
module kwdg_downcnt #(
  parameter int LOAD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LOAD_W-1:0] load_val,
  input  logic              ptick,
  output logic [LOAD_W-1:0] cnt,
  output logic              expire
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '1;
      expire <= 1'b0;
    end else begin
      expire <= ptick && (cnt == '0) && !load;
      if (load)                       cnt <= load_val;
      else if (ptick && cnt == '0)    cnt <= load_val;
      else if (ptick)                 cnt <= cnt - LOAD_W'(1);
    end
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwdg_pkg::*;
#(
  parameter int LOAD_W   = 12,
  parameter int CODE_W   = 4,
  parameter int MIN_LOG2 = 2,
  parameter int MAX_LOG2 = 10,
  parameter int SETTLE   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              wdg_rst_o
);
  logic              unlocked;
  key_cmd_t          cmd;
  logic              run_q;
  logic              arm_load;
  logic              ptick;
  logic [LOAD_W-1:0] cnt_q;
  logic [CODE_W-1:0] div_shadow, div_active;
  logic [LOAD_W-1:0] load_shadow, load_active;
  logic              div_pend, load_pend;
  logic [1:0]        stat_bits;
  logic              key_wr, div_wr, load_wr;

  assign key_wr  = reg_we && (reg_addr == OFS_KEY);
  assign div_wr  = reg_we && unlocked && (reg_addr == OFS_DIV);
  assign load_wr = reg_we && unlocked && (reg_addr == OFS_LOAD);

  kwdg_keyctl u_keyctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .key_val  (reg_wdata),
    .unlocked (unlocked),
    .cmd      (cmd)
  );

  kwdg_cfg_field #(.W(CODE_W), .RST('0), .SETTLE(SETTLE)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (div_wr),
    .wdata   (reg_wdata[CODE_W-1:0]),
    .tick_en (tick_en),
    .shadow  (div_shadow),
    .active  (div_active),
    .pending (div_pend)
  );

  kwdg_cfg_field #(.W(LOAD_W), .RST('1), .SETTLE(SETTLE)) u_load (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (load_wr),
    .wdata   (reg_wdata[LOAD_W-1:0]),
    .tick_en (tick_en),
    .shadow  (load_shadow),
    .active  (load_active),
    .pending (load_pend)
  );

  // Once set, only rst_n clears the run flag.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_q <= 1'b0;
    else if (cmd.start) run_q <= 1'b1;
  end

  // A feed, or the first start, reloads the counter and restarts the divider.
  assign arm_load = cmd.feed || (cmd.start && !run_q);

  kwdg_prescale #(.CODE_W(CODE_W), .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_q),
    .restart (arm_load),
    .tick_en (tick_en),
    .code    (div_active),
    .ptick   (ptick)
  );

  kwdg_downcnt #(.LOAD_W(LOAD_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (arm_load),
    .load_val (load_active),
    .ptick    (ptick),
    .cnt      (cnt_q),
    .expire   (wdg_rst_o)
  );

  assign stat_bits = {load_pend, div_pend};

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_DIV:  reg_rdata = DATA_W'(div_shadow);
      OFS_LOAD: reg_rdata = DATA_W'(load_shadow);
      OFS_STAT: reg_rdata = DATA_W'(stat_bits);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/kwdg_checker.sv
module kwdg_checker #(
  parameter int LOAD_W = 12,
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              wdg_rst_o,
  input logic              run,
  input logic              unlocked,
  input logic [CODE_W-1:0] div_shadow,
  input logic [LOAD_W-1:0] load_shadow,
  input logic [1:0]        stat,
  input logic [LOAD_W-1:0] cnt
);
  a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_rst_o |=> !wdg_rst_o);

  a_r1_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !wdg_rst_o);

  a_r9_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> run);

  a_r2_div_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(div_shadow));

  a_r2_load_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(load_shadow));

  a_r4_div_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[0] && !tick_en) |=> stat[0]);

  a_r4_load_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[1] && !tick_en) |=> stat[1]);

  a_r8_expire_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdg_rst_o) |-> ($past(cnt) == '0));
endmodule

bind keyed_watchdog kwdg_checker #(.LOAD_W(LOAD_W), .CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_en     (tick_en),
  .wdg_rst_o   (wdg_rst_o),
  .run         (run_q),
  .unlocked    (unlocked),
  .div_shadow  (div_shadow),
  .load_shadow (load_shadow),
  .stat        (stat_bits),
  .cnt         (cnt_q)
);

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        wdg_rst_o;

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  keyed_watchdog u_keyed_watchdog (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wdg_rst_o(wdg_rst_o)
  );

  always @(posedge clk) begin
    #1;
    if (wdg_rst_o) pulses++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick_en = 1'b0; reg_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    pulses = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    #1 v = int'(reg_rdata);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic setup(input int code, input int load);
    wr(5'h00, 16'h5555);
    wr(5'h04, 16'(code));
    wr(5'h08, 16'(load));
    wr(5'h00, 16'h0000);
    ticks(2);
  endtask

  task automatic t_reset();
    int v;
    do_reset();
    check("R1 pulse", int'(wdg_rst_o), 0);
    rd(5'h04, v); check("R1 div", v, 0);
    rd(5'h08, v); check("R1 load", v, 'hFFF);
    rd(5'h0C, v); check("R1 status", v, 0);
    ticks(50);
    check("R1 no pulse unarmed", pulses, 0);
  endtask

  task automatic t_lock();
    int v;
    wr(5'h04, 16'h0003);
    wr(5'h08, 16'h0005);
    rd(5'h04, v); check("R2 div locked", v, 0);
    rd(5'h08, v); check("R2 load locked", v, 'hFFF);
    rd(5'h0C, v); check("R2 status", v, 0);
  endtask

  task automatic t_unlock_status();
    int v;
    wr(5'h00, 16'h5555);
    wr(5'h08, 16'h0002);
    rd(5'h08, v); check("R3 load open", v, 2);
    rd(5'h0C, v); check("R4 load pend", v, 2);
    ticks(1);
    rd(5'h0C, v); check("R4 pend after 1 tick", v, 2);
    ticks(1);
    rd(5'h0C, v); check("R4 pend cleared", v, 0);
    wr(5'h04, 16'h0001);
    rd(5'h0C, v); check("R4 div pend", v, 1);
    ticks(2);
    rd(5'h0C, v); check("R4 div cleared", v, 0);
    wr(5'h00, 16'h1234);
    wr(5'h04, 16'h0005);
    rd(5'h04, v); check("R3 relock other key", v, 1);
    wr(5'h00, 16'h5555);
    wr(5'h00, 16'h0000);
    wr(5'h08, 16'h0007);
    rd(5'h08, v); check("R3 relock zero key", v, 2);
  endtask

  task automatic t_window();
    int v;
    wr(5'h00, 16'h5555);
    wr(5'h10, 16'hFFFF);
    rd(5'h10, v); check("R10 window reads 0", v, 0);
    rd(5'h0C, v); check("R10 status", v, 0);
    rd(5'h04, v); check("R10 div kept", v, 1);
    rd(5'h08, v); check("R10 load kept", v, 2);
    wr(5'h00, 16'h0000);
  endtask

  task automatic t_timeout_feed_stop();
    do_reset();
    setup(0, 2);
    wr(5'h00, 16'hCCCC);
    ticks(11);
    check("R5 not before 12", pulses, 0);
    ticks(1);
    check("R5 pulse at 12", pulses, 1);
    repeat (4) @(negedge clk);
    check("R5 one cycle", pulses, 1);
    ticks(12);
    check("R8 auto reload", pulses, 2);
    ticks(10);
    wr(5'h00, 16'hAAAA);
    ticks(11);
    check("R7 feed delays", pulses, 2);
    ticks(1);
    check("R7 expiry after feed", pulses, 3);
    wr(5'h00, 16'h0000);
    wr(5'h00, 16'h1234);
    ticks(12);
    check("R9 keys do not stop", pulses, 4);
    do_reset();
    ticks(30);
    check("R9 reset stops", pulses, 0);
  endtask

  task automatic t_divider();
    int v;
    do_reset();
    setup(1, 2);
    wr(5'h00, 16'hCCCC);
    ticks(23);
    check("R6 code1 not early", pulses, 0);
    ticks(1);
    check("R6 code1 at 24", pulses, 1);
    do_reset();
    setup(9, 0);
    rd(5'h04, v); check("R6 code9 readback", v, 9);
    wr(5'h00, 16'hCCCC);
    ticks(1023);
    check("R6 saturate not early", pulses, 0);
    ticks(1);
    check("R6 saturate at 1024", pulses, 1);
  endtask

  initial begin
    t_reset();
    t_lock();
    t_unlock_status();
    t_window();
    t_timeout_feed_stop();
    t_divider();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule